// File: doc/BRIEF.md
# Carrier NCO Down-Converter with Serial Offset Load

This block mixes a stream of complex samples with a locally generated carrier. The carrier comes from a phase accumulator. The accumulator's step is the sum of two frequency words. The host sets the base word by first writing a holding register and then pulsing a load strobe. The offset word arrives one bit per clock on a serial line. It is framed by a sync pulse and takes effect only once the whole word has arrived, so the carrier can be steered finely with few pins.

A 2-bit quadrant code turns the carrier in steps of a quarter turn. Samples can be given in two's complement or in offset binary. A sample is taken only on cycles with the active-low enable low. The phase accumulator advances only on those cycles as well. Each accepted sample comes out as a rotated I/Q pair with a valid flag, a fixed number of cycles later.

Top module: `carrier_nco`

## Requirements
- R1: While reset is asserted and just after it is released, `i_o`, `q_o`, `valid_o` are 0, and the accumulator, base, offset and holding words are all 0.
- R2: A sample is taken only at a rising edge with `en_ni` low. At an edge with `en_ni` high the phase does not advance, and no valid output results from that edge.
- R3: `valid_o` is high exactly 3 rising edges after an edge that took a sample (the output is visible after the third edge, counting the sampling edge).
- R4: With `fmt_i`=0 the inputs are two's complement. With `fmt_i`=1 they are offset binary, and bit 9 is inverted before mixing. `fmt_i` is sampled with the data.
- R5: At an edge with `freq_ld_i` high, the base word takes the holding word. The phase step is (base + offset) mod 2^32, and the accumulator is 32 bits.
- R6: A holding write (`hold_wr_i`) at an edge where `freq_ld_i` is high is ignored. The holding word keeps its old value.
- R7: After an edge with `ofs_sync_i` high, the next 32 edges shift in `ofs_data_i`, MSB first. The new offset word is active from the edge after the 32nd bit. Before that, the previous offset stays in use.
- R8: A sync pulse in the middle of a word drops the partial word and restarts the bit count. The active offset does not change at that edge.
- R9: The table address is phase[31:24] plus 64 times `quad_i` (mod 256), which rotates the carrier by 0, 90, 180 or 270 degrees for codes 00, 01, 10 or 11.
- R10: Let u = j(128-j) and d = 81920-4u. For table index k (0..255), j = k mod 128, and S[k] = ±floor((8176u + d/2)/d), negative for k≥128. S[k] is the sine, and C[k] = S[(k+64) mod 256] is the cosine.
- R11: Outputs are i_o = round(I·C + Q·S) and q_o = round(Q·C − I·S). Here round(x) = (x+256)>>>9, taken as 12 bits. A sample uses the phase from before the increment at its own edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_ni | input | 1 | Sample enable, active low |
| fmt_i | input | 1 | Input format: 0 two's complement, 1 offset binary |
| i_i | input | 10 | In-phase sample |
| q_i | input | 10 | Quadrature sample |
| quad_i | input | 2 | Carrier quadrant rotation code |
| hold_wr_i | input | 1 | Write strobe for the holding word |
| hold_data_i | input | 32 | Holding word data |
| freq_ld_i | input | 1 | Transfers the holding word to the base word |
| ofs_sync_i | input | 1 | Sync pulse, one cycle ahead of the offset MSB |
| ofs_data_i | input | 1 | Serial offset data, MSB first |
| i_o | output | 12 | Mixed in-phase result |
| q_o | output | 12 | Mixed quadrature result |
| valid_o | output | 1 | Result valid |

## Verification
The assertions assume that control inputs are stable at each rising edge. They also assume that reset is held long enough for every register to clear. Under those conditions the valid flag follows the enable with a delay of three edges. The sync checks also rely on the sender never asserting a sync pulse on the same edge as the final offset bit. The stimulus changes every input only on the falling edge. Every serial word is sent as a sync cycle followed by 32 bit cycles. The one exception is the deliberate restart, which breaks off a word and then sends a fresh sync.

// File: rtl/nco_pkg.sv
package nco_pkg;
  // Integer sine approximation, half wave of 2^(aw-1) entries, peak 2^(tw-1)-1
  function automatic int sin_entry(int k, int aw, int tw);
    longint h, j, u, amp, d, v;
    h   = longint'(1) << (aw - 1);
    j   = longint'(k) % h;
    u   = j * (h - j);
    amp = (longint'(1) << (tw - 1)) - 1;
    d   = 5 * h * h - 4 * u;
    v   = (amp * 16 * u + d / 2) / d;
    return (longint'(k) < h) ? int'(v) : -int'(v);
  endfunction
endpackage

// File: rtl/nco_offset_rx.sv
module nco_offset_rx #(
  parameter int FW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_i,
  input  logic          sdata_i,
  output logic [FW-1:0] off_o
);
  localparam int CW = $clog2(FW);

  logic [FW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [FW-1:0] sh_nxt;

  assign sh_nxt = {sh_q[FW-2:0], sdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      off_o  <= '0;
    end else if (sync_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      sh_q  <= sh_nxt;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(FW - 1)) begin
        off_o  <= sh_nxt;
        busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int FW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          wr_i,
  input  logic [FW-1:0] wdata_i,
  input  logic          load_i,
  input  logic [FW-1:0] off_i,
  output logic [FW-1:0] hold_o,
  output logic [FW-1:0] base_o,
  output logic [FW-1:0] phase_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o  <= '0;
      base_o  <= '0;
      phase_o <= '0;
    end else begin
      if (load_i)    base_o <= hold_o;
      else if (wr_i) hold_o <= wdata_i;  // writes blocked under load
      if (step_i)    phase_o <= phase_o + base_o + off_i;
    end
  end
endmodule

// File: rtl/nco_sincos_rom.sv
module nco_sincos_rom #(
  parameter int AW = 8,
  parameter int TW = 10
) (
  input  logic [AW-1:0]        addr_i,
  output logic signed [TW-1:0] sin_o,
  output logic signed [TW-1:0] cos_o
);
  localparam int N = 1 << AW;
  localparam logic [AW-1:0] QTR = AW'(N / 4);

  logic signed [TW-1:0] rom [N];

  for (genvar k = 0; k < N; k++) begin : g_rom
    localparam logic signed [TW-1:0] ENT = TW'(nco_pkg::sin_entry(k, AW, TW));
    assign rom[k] = ENT;
  end

  assign sin_o = rom[addr_i];
  assign cos_o = rom[addr_i + QTR];
endmodule

// File: rtl/carrier_nco.sv
module carrier_nco #(
  parameter int DW = 10,
  parameter int FW = 32,
  parameter int AW = 8,
  parameter int TW = 10,
  parameter int OW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_ni,
  input  logic          fmt_i,
  input  logic [DW-1:0] i_i,
  input  logic [DW-1:0] q_i,
  input  logic [1:0]    quad_i,
  input  logic          hold_wr_i,
  input  logic [FW-1:0] hold_data_i,
  input  logic          freq_ld_i,
  input  logic          ofs_sync_i,
  input  logic          ofs_data_i,
  output logic [OW-1:0] i_o,
  output logic [OW-1:0] q_o,
  output logic          valid_o
);
  localparam int MW = DW + TW;
  localparam int PW = MW + 1;
  localparam int SH = PW - OW;
  localparam int RNDV = 1 << (SH - 1);

  logic [FW-1:0] hold_q, base_q, off_q, phase_q;
  logic [AW-1:0] addr_c;
  logic [DW-1:0] fmt_mask;

  nco_offset_rx #(.FW(FW)) u_ofs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_i  (ofs_sync_i),
    .sdata_i (ofs_data_i),
    .off_o   (off_q)
  );

  nco_phase_acc #(.FW(FW)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (!en_ni),
    .wr_i    (hold_wr_i),
    .wdata_i (hold_data_i),
    .load_i  (freq_ld_i),
    .off_i   (off_q),
    .hold_o  (hold_q),
    .base_o  (base_q),
    .phase_o (phase_q)
  );

  assign addr_c   = phase_q[FW-1 -: AW] + {quad_i, {(AW-2){1'b0}}};
  assign fmt_mask = {fmt_i, {(DW-1){1'b0}}};

  // stage 1: capture
  logic signed [DW-1:0] i_s1, q_s1, i_s2, q_s2;
  logic [AW-1:0]        addr_s1;
  logic                 v_s1, v_s2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_s1 <= '0; q_s1 <= '0; addr_s1 <= '0; v_s1 <= 1'b0;
    end else begin
      v_s1 <= !en_ni;
      if (!en_ni) begin
        i_s1    <= i_i ^ fmt_mask;
        q_s1    <= q_i ^ fmt_mask;
        addr_s1 <= addr_c;
      end
    end
  end

  // stage 2: table lookup
  logic signed [TW-1:0] sin_c, cos_c, sin_s2, cos_s2;

  nco_sincos_rom #(.AW(AW), .TW(TW)) u_rom (
    .addr_i (addr_s1),
    .sin_o  (sin_c),
    .cos_o  (cos_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_s2 <= '0; q_s2 <= '0; sin_s2 <= '0; cos_s2 <= '0; v_s2 <= 1'b0;
    end else begin
      v_s2 <= v_s1;
      if (v_s1) begin
        i_s2 <= i_s1; q_s2 <= q_s1; sin_s2 <= sin_c; cos_s2 <= cos_c;
      end
    end
  end

  // stage 3: complex multiply and round
  logic signed [MW-1:0] m_ic, m_qs, m_qc, m_is;
  logic signed [PW-1:0] sum_i, sum_q, rnd_i, rnd_q;

  always_comb begin
    m_ic  = i_s2 * cos_s2;
    m_qs  = q_s2 * sin_s2;
    m_qc  = q_s2 * cos_s2;
    m_is  = i_s2 * sin_s2;
    sum_i = PW'(m_ic) + PW'(m_qs);
    sum_q = PW'(m_qc) - PW'(m_is);
    rnd_i = (sum_i + PW'(RNDV)) >>> SH;
    rnd_q = (sum_q + PW'(RNDV)) >>> SH;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_o <= '0; q_o <= '0; valid_o <= 1'b0;
    end else begin
      valid_o <= v_s2;
      if (v_s2) begin
        i_o <= rnd_i[OW-1:0];
        q_o <= rnd_q[OW-1:0];
      end
    end
  end
endmodule

// File: rtl/carrier_nco_chk.sv
module carrier_nco_chk #(
  parameter int FW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_ni,
  input logic          hold_wr_i,
  input logic          freq_ld_i,
  input logic          ofs_sync_i,
  input logic          valid_o,
  input logic [FW-1:0] hold_q,
  input logic [FW-1:0] base_q,
  input logic [FW-1:0] off_q,
  input logic [FW-1:0] phase_q
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 1'b1;
  end

  p_valid_lat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd3) |-> (valid_o == $past(!en_ni, 3)));

  p_phase_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_ni |=> $stable(phase_q));

  p_base_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freq_ld_i |=> (base_q == $past(hold_q)));

  p_base_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !freq_ld_i |=> $stable(base_q));

  p_hold_block_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freq_ld_i && hold_wr_i) |=> $stable(hold_q));

  p_sync_no_commit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ofs_sync_i |=> $stable(off_q));
endmodule

bind carrier_nco carrier_nco_chk #(.FW(FW)) u_chk (.*);

// File: tb/carrier_nco_bench.sv
module carrier_nco_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_n = 1'b1, fmt = 1'b0;
  logic [9:0]  i_in = '0, q_in = '0;
  logic [1:0]  quad = '0;
  logic        wr = 1'b0, ld = 1'b0, sync = 1'b0, sdat = 1'b0;
  logic [31:0] wdata = '0;
  logic [11:0] i_out, q_out;
  logic        v_out;

  always #2 clk = ~clk;

  carrier_nco u_carrier_nco (
    .clk_i(clk), .rst_ni(rst_n), .en_ni(en_n), .fmt_i(fmt), .i_i(i_in), .q_i(q_in),
    .quad_i(quad), .hold_wr_i(wr), .hold_data_i(wdata), .freq_ld_i(ld),
    .ofs_sync_i(sync), .ofs_data_i(sdat), .i_o(i_out), .q_o(q_out), .valid_o(v_out)
  );

  int    n_vec = 0, n_bad = 0;
  string tag = "R1";
  bit    stream = 1'b0;
  int    en_pct = 70;

  // reference model state
  longint m_hold, m_base, m_off, m_phase, m_sh;
  int     m_cnt;
  bit     m_act;
  bit     ev[3];
  int     ei[3], eq[3];

  function automatic int tsin(int k);  // R10
    longint j, u, d, v;
    j = k % 128;
    u = j * (128 - j);
    d = 81920 - 4 * u;
    v = (8176 * u + d / 2) / d;
    return (k < 128) ? int'(v) : -int'(v);
  endfunction

  function automatic int to_int(logic [9:0] x, logic f);  // R4
    int v;
    v = int'(f ? (x ^ 10'h200) : x);
    return (v >= 512) ? v - 1024 : v;
  endfunction

  function automatic int rnd(int s);  // R11
    return (s + 256) >>> 9;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hold = 0; m_base = 0; m_off = 0; m_phase = 0; m_sh = 0; m_cnt = 0; m_act = 0;
      for (int k = 0; k < 3; k++) begin ev[k] = 0; ei[k] = 0; eq[k] = 0; end
    end else begin
      for (int k = 2; k > 0; k--) begin ev[k] = ev[k-1]; ei[k] = ei[k-1]; eq[k] = eq[k-1]; end
      ev[0] = 0;
      if (!en_n) begin
        int a, si, sq, c, s;
        si = to_int(i_in, fmt);
        sq = to_int(q_in, fmt);
        a  = (int'(m_phase >> 24) + int'(quad) * 64) % 256;
        s  = tsin(a);
        c  = tsin((a + 64) % 256);
        ev[0] = 1;
        ei[0] = rnd(si * c + sq * s);
        eq[0] = rnd(sq * c - si * s);
        m_phase = (m_phase + m_base + m_off) & 64'hFFFF_FFFF;
      end
      if (ld) m_base = m_hold;
      else if (wr) m_hold = longint'(wdata);
      if (sync) begin
        m_act = 1; m_cnt = 0; m_sh = 0;
      end else if (m_act) begin
        m_sh = ((m_sh << 1) | longint'(sdat)) & 64'hFFFF_FFFF;
        m_cnt++;
        if (m_cnt == 32) begin m_off = m_sh; m_act = 0; end
      end
    end
  end

  task automatic compare();
    n_vec++;
    if (v_out !== ev[2]) begin
      n_bad++;
      $display("FAIL R3 (%s) valid_o act=%0b exp=%0b t=%0t", tag, v_out, ev[2], $time);
    end else if (ev[2] && ($signed(i_out) !== ei[2] || $signed(q_out) !== eq[2])) begin
      n_bad++;
      $display("FAIL R11 (%s) i/q act=%0d/%0d exp=%0d/%0d t=%0t", tag,
               $signed(i_out), $signed(q_out), ei[2], eq[2], $time);
    end
  endtask

  task automatic tick();
    if (stream) begin
      en_n = (($urandom % 100) >= en_pct);
      i_in = 10'($urandom);
      q_in = 10'($urandom);
    end
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic load_base(logic [31:0] w);
    wr = 1'b1; wdata = w; tick();
    wr = 1'b0; ld = 1'b1; tick();
    ld = 1'b0;
  endtask

  task automatic send_ofs(logic [31:0] w, int nbits);  // R7
    sync = 1'b1; tick();
    sync = 1'b0;
    for (int b = 0; b < nbits; b++) begin
      sdat = w[31-b]; tick();
    end
    sdat = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    #10;
    n_vec++;
    if (v_out !== 1'b0 || i_out !== '0 || q_out !== '0) begin
      n_bad++;
      $display("FAIL R1 reset outputs act=%0b/%0h/%0h exp=0/0/0", v_out, i_out, q_out);
    end
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 4; k++) tick();

    // R9, R10: zero frequency, quadrant steps pick fixed table points
    tag = "R9"; stream = 1'b1;
    for (int qd = 0; qd < 4; qd++) begin
      quad = 2'(qd);
      for (int k = 0; k < 20; k++) tick();
    end
    quad = 2'd0;

    // R2: sparse enable
    tag = "R2"; en_pct = 20;
    for (int k = 0; k < 60; k++) tick();
    en_pct = 70;

    // R5: base word loaded, one table step per sample
    tag = "R5";
    load_base(32'h0100_0000);
    for (int k = 0; k < 300; k++) tick();
    load_base(32'h0345_6789);
    for (int k = 0; k < 200; k++) tick();

    // R4: offset binary input
    tag = "R4"; fmt = 1'b1;
    for (int k = 0; k < 100; k++) tick();
    fmt = 1'b0;

    // R7: serial offset word, full frame
    tag = "R7";
    send_ofs(32'h0080_0000, 32);
    for (int k = 0; k < 100; k++) tick();
    send_ofs(32'hFE00_1234, 32);
    for (int k = 0; k < 100; k++) tick();

    // R8: restart mid-word, then complete word
    tag = "R8";
    send_ofs(32'h7FFF_FFFF, 13);
    for (int k = 0; k < 5; k++) tick();
    send_ofs(32'h0123_4567, 20);
    send_ofs(32'h0040_0001, 32);
    for (int k = 0; k < 100; k++) tick();

    // R6: write during load is dropped
    tag = "R6";
    wr = 1'b1; wdata = 32'h0200_0000; tick();
    ld = 1'b1; wdata = 32'h5555_5555; tick();
    wr = 1'b0; ld = 1'b1; tick();
    ld = 1'b0;
    for (int k = 0; k < 200; k++) tick();

    // mixed random traffic
    tag = "R11";
    for (int k = 0; k < 3000; k++) begin
      quad = 2'($urandom);
      fmt  = 1'($urandom);
      if ((k % 400) == 7) load_base($urandom);
      else if ((k % 500) == 100) send_ofs($urandom, 32);
      else tick();
    end
    stream = 1'b0; en_n = 1'b1;
    for (int k = 0; k < 5; k++) tick();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule